// File: doc/BRIEF.md
# Paired-Side Integration Sequencer

This block sequences the two integrator sides (A and B) of an integrating current-input converter when it runs with gaps between integrations. A level change on the conversion input (`conv_i`) is the only command. Each change either starts a pair of integrations, moves from the first side of the pair to the second, or closes the pair. After a pair both sides go through a measure/reset/auto-zero (m/r/az) cycle. During that time no side integrates. The next pair is held back until the controller is free again.

The controller reports its numbered state, which side is integrating, which side is in m/r/az, and a measurement-busy flag. It also produces an active-low data-valid strobe with a side tag, one strobe for each result of the pair. The analog path and the result readout are not modelled. Their durations appear only as cycle counts. The defaults are derived from nanosecond figures at a clock-rate parameter, and a bench may override them with short values.

State numbering (visible on `state_o`):
- 1: draining, waiting for both m/r/az cycles and both results.
- 2: preparation, then ready.
- 3: integrating A as the first side of a pair.
- 4: integrating B as the second side.
- 5: integrating A as the second side.
- 6: integrating B as the first side.

Top module: `pairint_ctl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `state_o` is 2, no side integrates, no side is in m/r/az, `mbsy_o` is 0 and `dvalid_n_o` is 1.
- R2: A level change of `conv_i` sampled in the ready state starts a pair at that clock edge. If the new level is 1, the pair starts in state 3 with `int_a_o` high (A first). If the new level is 0, it starts in state 6 with `int_b_o` high (B first).
- R3: The next level change moves state 3 to 4 or state 6 to 5, and the other side integrates. The change after that moves to state 1 with neither side integrating. The two integrate flags are never high together.
- R4: A side's m/r/az flag (`mraz_a_o`/`mraz_b_o`) rises at the edge where that side's integration ends. It stays high for exactly MRAZ_CYC cycles.
- R5: States 3 and 6 are never entered while either m/r/az cycle or a result of the last pair is pending. Let G be the later of two edges: second-side end plus MRAZ_CYC, and first-side end plus DV1_CYC+DV2_CYC. State 1 moves to state 2 at edge G+1. `mbsy_o` falls at edge G+PREP_CYC+1, with state 2 held and no integration.
- R6: `mbsy_o` is high whenever a side is in m/r/az, in state 1, or in the preparation part of state 2. It is low in the ready state and during a first-side integration that overlaps no m/r/az cycle.
- R7: Level changes arriving while the controller is busy (state 1 or preparation) are latched and merged into one request. That request starts the pair one edge after `mbsy_o` falls, at edge G+PREP_CYC+2. The start side follows the `conv_i` level at that edge (1: A, 0: B).
- R8: `dvalid_n_o` is low for exactly one cycle, DV1_CYC cycles after the edge that ends the first integration of a pair. `dside_o` then gives the first side (0 = A, 1 = B).
- R9: A second one-cycle low pulse follows DV2_CYC cycles after the first, with `dside_o` naming the other side. No other data-valid pulses occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_i | input | 1 | Conversion command; every level change is an event |
| state_o | output | 3 | Sequencer state number (1 to 6) |
| int_a_o | output | 1 | Side A integrating |
| int_b_o | output | 1 | Side B integrating |
| mraz_a_o | output | 1 | Side A in m/r/az |
| mraz_b_o | output | 1 | Side B in m/r/az |
| mbsy_o | output | 1 | Measurement busy |
| dvalid_n_o | output | 1 | Active-low one-cycle data-valid strobe |
| dside_o | output | 1 | Side of the current result (0 = A, 1 = B) |

## Verification
The checker watches several rules on every cycle:
- both sides never integrate together;
- states 3 and 6 are entered only from a non-busy state 2;
- an m/r/az flag rises only as its side stops integrating;
- `mbsy_o` covers every m/r/az cycle and state 1;
- data-valid never stays low for two cycles;
- the second side of a pair only leaves to state 1.

Only the bench scenarios can show the exact cycle counts: the gate opening at G, the preparation delay, and the data-valid spacing and side order. The same holds for merging several busy-time level changes into one start whose side is taken from the level when the gate opens. Those scenarios vary integration lengths so that either the m/r/az cycle or the pending results set G.

// File: rtl/pairint_pkg.sv
package pairint_pkg;

    typedef enum logic [2:0] {
        ST_DRAIN = 3'd1,
        ST_PREP  = 3'd2,
        ST_A1ST  = 3'd3,
        ST_B2ND  = 3'd4,
        ST_A2ND  = 3'd5,
        ST_B1ST  = 3'd6
    } seq_state_e;

    localparam int unsigned NSIDE = 2;

    // Round a duration in ns to whole cycles of a clock given in kHz.
    function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                                 input longint unsigned khz);
        longint unsigned prod;
        prod = ns * khz + 64'd500000;
        return int'(prod / 64'd1000000);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pairint_side_mraz.sv
module pairint_side_mraz #(
    parameter int unsigned CW       = 16,
    parameter int unsigned MRAZ_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } mraz_t;

    mraz_t q, d;

    always_comb begin
        d = q;
        if (start_i) begin
            d.cnt = CW'(MRAZ_CYC);
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{cnt: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o = (q.cnt != '0);
endmodule

// File: rtl/pairint_result_seq.sv
module pairint_result_seq #(
    parameter int unsigned CW      = 16,
    parameter int unsigned DV1_CYC = 7,
    parameter int unsigned DV2_CYC = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic first_end_i,
    input  logic first_side_i,
    output logic dvalid_n_o,
    output logic dside_o,
    output logic busy_o
);
    typedef struct packed {
        logic [CW-1:0] tmr;
        logic          second;
        logic          side1;
        logic          pulse;
        logic          pside;
    } res_t;

    res_t q, d;

    always_comb begin
        d = q;
        d.pulse = 1'b0;
        if (first_end_i) begin
            d.tmr    = CW'(DV1_CYC);
            d.second = 1'b0;
            d.side1  = first_side_i;
        end else if (q.tmr != '0) begin
            d.tmr = q.tmr - 1'b1;
            if (q.tmr == CW'(1)) begin
                d.pulse = 1'b1;
                if (!q.second) begin
                    d.pside  = q.side1;
                    d.second = 1'b1;
                    d.tmr    = CW'(DV2_CYC);
                end else begin
                    d.pside  = ~q.side1;
                    d.second = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{tmr: '0, second: 1'b0, side1: 1'b0, pulse: 1'b0, pside: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign dvalid_n_o = ~q.pulse;
    assign dside_o    = q.pside;
    assign busy_o     = (q.tmr != '0);
endmodule

// File: rtl/pairint_ctl.sv
module pairint_ctl
    import pairint_pkg::*;
#(
    parameter int unsigned CLK_KHZ  = 10000,
    parameter int unsigned MRAZ_CYC = ns_to_cycles(910800, CLK_KHZ),
    parameter int unsigned PREP_CYC = ns_to_cycles(24000, CLK_KHZ),
    parameter int unsigned DV1_CYC  = ns_to_cycles(421200, CLK_KHZ),
    parameter int unsigned DV2_CYC  = ns_to_cycles(4548000, CLK_KHZ)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       conv_i,
    output logic [2:0] state_o,
    output logic       int_a_o,
    output logic       int_b_o,
    output logic       mraz_a_o,
    output logic       mraz_b_o,
    output logic       mbsy_o,
    output logic       dvalid_n_o,
    output logic       dside_o
);
    localparam int unsigned MAXC = max2(max2(MRAZ_CYC, PREP_CYC), max2(DV1_CYC, DV2_CYC));
    localparam int unsigned CW   = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] prep;
        logic          pend;
        logic          conv_prev;
    } ctl_t;

    ctl_t q, d;

    logic [NSIDE-1:0] mz_start;
    logic [NSIDE-1:0] mz_busy;
    logic             first_end;
    logic             first_side;
    logic             res_busy;
    logic             tog;
    logic             gate_open;

    always_comb begin
        d           = q;
        d.conv_prev = conv_i;
        tog         = conv_i ^ q.conv_prev;
        gate_open   = ~|mz_busy & ~res_busy;
        mz_start    = '0;
        first_end   = 1'b0;
        first_side  = 1'b0;
        unique case (q.st)
            ST_DRAIN: begin
                if (tog) d.pend = 1'b1;
                if (gate_open) begin
                    d.st   = ST_PREP;
                    d.prep = CW'(PREP_CYC);
                end
            end
            ST_PREP: begin
                if (q.prep != '0) begin
                    d.prep = q.prep - 1'b1;
                    if (tog) d.pend = 1'b1;
                end else if (tog || q.pend) begin
                    d.pend = 1'b0;
                    d.st   = conv_i ? ST_A1ST : ST_B1ST;
                end
            end
            ST_A1ST: begin
                if (tog) begin
                    d.st        = ST_B2ND;
                    mz_start[0] = 1'b1;
                    first_end   = 1'b1;
                    first_side  = 1'b0;
                end
            end
            ST_B1ST: begin
                if (tog) begin
                    d.st        = ST_A2ND;
                    mz_start[1] = 1'b1;
                    first_end   = 1'b1;
                    first_side  = 1'b1;
                end
            end
            ST_B2ND: begin
                if (tog) begin
                    d.st        = ST_DRAIN;
                    mz_start[1] = 1'b1;
                end
            end
            ST_A2ND: begin
                if (tog) begin
                    d.st        = ST_DRAIN;
                    mz_start[0] = 1'b1;
                end
            end
            default: d.st = ST_PREP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{st: ST_PREP, prep: '0, pend: 1'b0, conv_prev: conv_i};
        end else begin
            q <= d;
        end
    end

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        pairint_side_mraz #(
            .CW       (CW),
            .MRAZ_CYC (MRAZ_CYC)
        ) u_mraz (
            .clk     (clk),
            .rst     (rst),
            .start_i (mz_start[s]),
            .busy_o  (mz_busy[s])
        );
    end

    pairint_result_seq #(
        .CW      (CW),
        .DV1_CYC (DV1_CYC),
        .DV2_CYC (DV2_CYC)
    ) u_res (
        .clk          (clk),
        .rst          (rst),
        .first_end_i  (first_end),
        .first_side_i (first_side),
        .dvalid_n_o   (dvalid_n_o),
        .dside_o      (dside_o),
        .busy_o       (res_busy)
    );

    assign state_o  = q.st;
    assign int_a_o  = (q.st == ST_A1ST) || (q.st == ST_A2ND);
    assign int_b_o  = (q.st == ST_B1ST) || (q.st == ST_B2ND);
    assign mraz_a_o = mz_busy[0];
    assign mraz_b_o = mz_busy[1];
    assign mbsy_o   = (|mz_busy) || (q.st == ST_DRAIN) || ((q.st == ST_PREP) && (q.prep != '0));
endmodule

// File: rtl/pairint_chk.sv
module pairint_chk (
    input logic       clk,
    input logic       rst,
    input logic       conv_i,
    input logic [2:0] state_o,
    input logic       int_a_o,
    input logic       int_b_o,
    input logic       mraz_a_o,
    input logic       mraz_b_o,
    input logic       mbsy_o,
    input logic       dvalid_n_o,
    input logic       dside_o
);
    assert_one_side_R3: assert property (@(posedge clk) disable iff (rst)
        !(int_a_o && int_b_o));

    assert_second_exit_R3: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd4 || state_o == 3'd5) |=> (state_o == $past(state_o) || state_o == 3'd1));

    assert_mraz_a_begin_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mraz_a_o) |-> ($past(int_a_o) && !int_a_o));

    assert_mraz_b_begin_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mraz_b_o) |-> ($past(int_b_o) && !int_b_o));

    assert_start_gated_R5: assert property (@(posedge clk) disable iff (rst)
        ((state_o == 3'd3 || state_o == 3'd6) && !($past(state_o) == 3'd3 || $past(state_o) == 3'd6))
        |-> ($past(state_o) == 3'd2 && !$past(mbsy_o)));

    assert_busy_cover_R6: assert property (@(posedge clk) disable iff (rst)
        (mraz_a_o || mraz_b_o || state_o == 3'd1) |-> mbsy_o);

    assert_dv_single_R8: assert property (@(posedge clk) disable iff (rst)
        !dvalid_n_o |=> dvalid_n_o);
endmodule

bind pairint_ctl pairint_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .conv_i     (conv_i),
    .state_o    (state_o),
    .int_a_o    (int_a_o),
    .int_b_o    (int_b_o),
    .mraz_a_o   (mraz_a_o),
    .mraz_b_o   (mraz_b_o),
    .mbsy_o     (mbsy_o),
    .dvalid_n_o (dvalid_n_o),
    .dside_o    (dside_o)
);

// File: tb/sim_pairint_ctl.sv
module sim_pairint_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int MRAZ = 20;
    localparam int PREP = 4;
    localparam int DV1  = 7;
    localparam int DV2  = 30;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       conv = 1'b0;
    logic [2:0] state;
    logic       int_a, int_b, mraz_a, mraz_b, mbsy, dvalid_n, dside;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;

    int exp_dv1 = -1;
    int exp_dv2 = -1;
    bit exp_s1 = 1'b0;
    int mz_on[2]  = '{-1, -1};
    int mz_off[2] = '{-1, -1};

    pairint_ctl #(
        .MRAZ_CYC (MRAZ),
        .PREP_CYC (PREP),
        .DV1_CYC  (DV1),
        .DV2_CYC  (DV2)
    ) u0 (
        .clk        (clk),
        .rst        (rst),
        .conv_i     (conv),
        .state_o    (state),
        .int_a_o    (int_a),
        .int_b_o    (int_b),
        .mraz_a_o   (mraz_a),
        .mraz_b_o   (mraz_b),
        .mbsy_o     (mbsy),
        .dvalid_n_o (dvalid_n),
        .dside_o    (dside)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int start_state(input bit lvl);
        return lvl ? 3 : 6;
    endfunction

    // Result strobes and m/r/az windows, checked against bench-computed cycles
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            if (cyc == exp_dv1) begin
                check(!dvalid_n && dside == exp_s1, "R8", {dvalid_n, dside}, {1'b0, exp_s1});
            end else if (cyc == exp_dv2) begin
                check(!dvalid_n && dside == !exp_s1, "R9", {dvalid_n, dside}, {1'b0, !exp_s1});
            end else if (!dvalid_n) begin
                check(1'b0, "R9 spurious strobe", 0, 1);
            end
            for (int s = 0; s < 2; s++) begin
                if (cyc == mz_on[s])  check((s == 0 ? mraz_a : mraz_b) == 1'b1, "R4 start", 0, 1);
                if (cyc == mz_off[s]) check((s == 0 ? mraz_a : mraz_b) == 1'b0, "R4 end", 1, 0);
            end
        end
    end

    // One pair of integrations; mode 0: start later from ready, 1: one latched change, 2: two latched changes
    task automatic run_pair(input bit prestarted, input int len1, input int len2,
                            input int mode, output bit started);
        int e1, e2, g, first, waited;
        if (!prestarted) begin
            conv = ~conv;
            @(negedge clk);
        end
        first = conv ? 0 : 1;
        check(state == 3'(start_state(conv)), "R2 start state", state, start_state(conv));
        check(int_a == (first == 0) && int_b == (first == 1), "R2 side", {int_a, int_b}, first == 0 ? 2 : 1);
        check(!mbsy, "R6 idle during first side", mbsy, 0);
        repeat (len1 - 1) @(negedge clk);
        conv = ~conv;
        e1 = cyc + 1;
        exp_dv1 = e1 + DV1;
        exp_dv2 = e1 + DV1 + DV2;
        exp_s1 = first[0];
        mz_on[first]  = e1;
        mz_off[first] = e1 + MRAZ;
        @(negedge clk);
        check(state == (first == 0 ? 3'd4 : 3'd5), "R3 second state", state, first == 0 ? 4 : 5);
        check(int_a == (first == 1) && int_b == (first == 0), "R3 second side", {int_a, int_b}, first == 0 ? 1 : 2);
        check(mbsy, "R6 busy while first side in m/r/az", mbsy, 1);
        repeat (len2 - 1) @(negedge clk);
        conv = ~conv;
        e2 = cyc + 1;
        mz_on[1 - first]  = e2;
        mz_off[1 - first] = e2 + MRAZ;
        @(negedge clk);
        check(state == 3'd1 && !int_a && !int_b, "R3 pair closed", state, 1);
        g = max_i(e2 + MRAZ, e1 + DV1 + DV2);
        if (mode > 0) begin
            repeat ($urandom_range(MRAZ - 1, 0)) @(negedge clk);
            conv = ~conv;
            if (mode == 2) begin
                @(negedge clk);
                conv = ~conv;
            end
        end
        waited = 0;
        while (mbsy && waited < 500) begin
            @(negedge clk);
            waited++;
        end
        check(cyc == g + PREP + 1, "R5 ready cycle", cyc, g + PREP + 1);
        check(state == 3'd2 && !int_a && !int_b, "R5 held in state 2", state, 2);
        if (mode > 0) begin
            @(negedge clk);
            check(cyc == g + PREP + 2 && state == 3'(start_state(conv)), "R7 latched start",
                  state, start_state(conv));
            started = 1'b1;
        end else begin
            repeat ($urandom_range(4, 1)) @(negedge clk);
            check(!mbsy && state == 3'd2, "R6 ready stays free", mbsy, 0);
            started = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit st;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        check(state == 3'd2 && !int_a && !int_b && !mraz_a && !mraz_b && !mbsy && dvalid_n,
              "R1 during reset", state, 2);
        rst = 1'b0;
        @(negedge clk);
        check(state == 3'd2 && !int_a && !int_b && !mraz_a && !mraz_b && !mbsy && dvalid_n,
              "R1 after reset", state, 2);
        mon_on = 1'b1;
        repeat (3) @(negedge clk);
        check(state == 3'd2 && !int_a && !int_b, "R1 idle without change", state, 2);

        st = 1'b0;
        run_pair(st, 1, 1, 0, st);
        run_pair(st, 1, 1, 1, st);
        run_pair(st, 5, 25, 2, st);
        run_pair(st, 30, 1, 0, st);
        run_pair(st, 2, 40, 1, st);
        for (int i = 0; i < 40; i++) begin
            run_pair(st, $urandom_range(30, 1), $urandom_range(30, 1), $urandom_range(2, 0), st);
        end
        run_pair(st, 3, 3, 0, st);
        repeat (10) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule